// File: doc/BRIEF.md
# Multi-Channel Memory Request Arbiter

This block connects a set of requesters to an external memory that can work on a fixed number of transfers at once. Each requester has a read port and a write port, both using valid/ready. The memory side has one read port and one write port per channel. Each channel is a small independent engine. When free, it looks for a requester with a pending request and forwards that request to memory. It waits for memory to complete the transfer, then returns the result to the requester. It frees itself only after the requester has withdrawn its request, so every transfer follows a full four-phase handshake.

A requester that is already being handled by one channel is invisible to every other channel. Free channels claim requesters in channel-index order within a cycle, so no request is ever issued twice. A parameter removes the write path for read-only memories.

Top module: `mem_chan_arbiter`

## Requirements
- R1: While rst_ni is low, every memory read/write valid output and every requester read/write ready output is 0.
- R2: A channel that takes a read raises its memory read valid the cycle after the request is first seen, carrying the requester's read address. Valid and address then stay unchanged until memory read ready is seen high.
- R3: On the clock edge where memory read ready is high, the channel drops memory read valid. From that edge it drives the requester's read ready high, with read data equal to the memory read data sampled at that edge.
- R4: The requester's read ready and read data stay unchanged while its read valid stays high. Ready goes to 0 at the first edge where read valid is seen low, and the channel becomes free.
- R5: A write raises memory write valid with the requester's write address and data, held until memory write ready is seen. Then memory write valid drops and the requester's write ready stays high until its write valid is seen low.
- R6: A free channel takes the lowest-indexed eligible requester. When several channels are free in one cycle, channel 0 takes first, channel 1 takes the next-lowest remaining requester, and so on.
- R7: At most one channel serves a requester at a time. A requester being served is not taken by another channel. It becomes eligible again one cycle after the edge that frees its channel.
- R8: When one requester has both read valid and write valid high, the read is served first and the write only after that read has completed.
- R9: With the write path disabled (WR_EN=0), write inputs are ignored. Memory write valid and requester write ready stay 0, and a requester with only a write pending is skipped by the scan.
- R10: Channels are independent: a channel waiting on memory does not stop another channel from taking, completing or releasing a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cons_rd_vld_i | input | N_CONS | Requester read valid, one bit per requester |
| cons_rd_addr_i | input | N_CONS*ADDR_W | Requester read addresses, requester j at bits j*ADDR_W |
| cons_rd_rdy_o | output | N_CONS | Requester read ready (response present) |
| cons_rd_data_o | output | N_CONS*DATA_W | Requester read data, requester j at bits j*DATA_W |
| cons_wr_vld_i | input | N_CONS | Requester write valid |
| cons_wr_addr_i | input | N_CONS*ADDR_W | Requester write addresses |
| cons_wr_data_i | input | N_CONS*DATA_W | Requester write data |
| cons_wr_rdy_o | output | N_CONS | Requester write ready (write done) |
| mem_rd_vld_o | output | N_CHAN | Memory read valid per channel |
| mem_rd_addr_o | output | N_CHAN*ADDR_W | Memory read address per channel |
| mem_rd_rdy_i | input | N_CHAN | Memory read ready per channel |
| mem_rd_data_i | input | N_CHAN*DATA_W | Memory read data per channel |
| mem_wr_vld_o | output | N_CHAN | Memory write valid per channel |
| mem_wr_addr_o | output | N_CHAN*ADDR_W | Memory write address per channel |
| mem_wr_data_o | output | N_CHAN*DATA_W | Memory write data per channel |
| mem_wr_rdy_i | input | N_CHAN | Memory write ready per channel |

## Verification
The bench makes two channels free in the same cycle while three requesters are pending. A design that lets every channel see the same stale busy mask would issue one requester twice and starve another. It holds a requester's read valid high through a long response phase. A channel that frees itself early would drop ready, or a second channel would reissue the request. It raises read and write together on one requester, which exposes a design that services the write first or runs both at once. It also checks that the requester is retaken exactly one cycle after release, which catches an off-by-one in release. It drives write-only requests into a read-only instance, where a wrong design would raise a memory write or park a channel on a request it cannot serve.

// File: rtl/mca_pkg.sv
package mca_pkg;
  typedef enum logic [2:0] {
    CH_IDLE,
    CH_RD_WAIT,
    CH_RD_RELAY,
    CH_WR_WAIT,
    CH_WR_RELAY
  } ch_state_e;
endpackage

// File: rtl/mca_pick.sv
// Claim chain: free channels scan requesters in channel order, each
// seeing the claims made by lower-numbered channels this cycle.
module mca_pick #(
  parameter int N_CONS = 4,
  parameter int N_CHAN = 2,
  parameter int IW     = 2
) (
  input  logic [N_CHAN-1:0]    idle_i,
  input  logic [N_CONS-1:0]    rd_vld_i,
  input  logic [N_CONS-1:0]    wr_vld_i,
  input  logic [N_CONS-1:0]    busy_i,
  output logic [N_CHAN-1:0]    take_o,
  output logic [N_CHAN*IW-1:0] take_idx_o,
  output logic [N_CHAN-1:0]    take_wr_o
);
  logic [N_CONS-1:0] mask;

  always_comb begin
    mask       = busy_i;
    take_o     = '0;
    take_idx_o = '0;
    take_wr_o  = '0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (idle_i[c]) begin
        for (int j = 0; j < N_CONS; j++) begin
          if (!take_o[c] && !mask[j] && (rd_vld_i[j] || wr_vld_i[j])) begin
            take_o[c]               = 1'b1;
            take_idx_o[c*IW +: IW]  = IW'(j);
            take_wr_o[c]            = !rd_vld_i[j];  // read wins
            mask[j]                 = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mca_channel.sv
module mca_channel
  import mca_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              take_wr_i,
  input  logic [IW-1:0]     take_idx_i,
  input  logic [ADDR_W-1:0] take_addr_i,
  input  logic [DATA_W-1:0] take_data_i,
  input  logic              own_rd_vld_i,
  input  logic              own_wr_vld_i,
  input  logic              mem_rd_rdy_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  input  logic              mem_wr_rdy_i,
  output ch_state_e         state_o,
  output logic [IW-1:0]     idx_o,
  output logic              mem_rd_vld_o,
  output logic              mem_wr_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rsp_o
);
  ch_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
      idx_o   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
      rsp_o   <= '0;
    end else begin
      unique case (state_q)
        CH_IDLE: if (take_i) begin
          idx_o   <= take_idx_i;
          addr_o  <= take_addr_i;
          wdata_o <= take_data_i;
          state_q <= take_wr_i ? CH_WR_WAIT : CH_RD_WAIT;
        end
        CH_RD_WAIT: if (mem_rd_rdy_i) begin
          rsp_o   <= mem_rd_data_i;
          state_q <= CH_RD_RELAY;
        end
        CH_RD_RELAY: if (!own_rd_vld_i) state_q <= CH_IDLE;
        CH_WR_WAIT:  if (mem_wr_rdy_i)  state_q <= CH_WR_RELAY;
        CH_WR_RELAY: if (!own_wr_vld_i) state_q <= CH_IDLE;
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign mem_rd_vld_o = (state_q == CH_RD_WAIT);
  assign mem_wr_vld_o = (state_q == CH_WR_WAIT);

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_vld_o && !mem_rd_rdy_i |=> mem_rd_vld_o && $stable(addr_o));
  // R3
  rd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_vld_o && mem_rd_rdy_i |=> !mem_rd_vld_o && (rsp_o == $past(mem_rd_data_i)));
  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_vld_o && !mem_wr_rdy_i |=> mem_wr_vld_o && $stable(addr_o) && $stable(wdata_o));
endmodule

// File: rtl/mem_chan_arbiter.sv
module mem_chan_arbiter
  import mca_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int N_CONS = 4,
  parameter int N_CHAN = 2,
  parameter bit WR_EN  = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CONS-1:0]        cons_rd_vld_i,
  input  logic [N_CONS*ADDR_W-1:0] cons_rd_addr_i,
  output logic [N_CONS-1:0]        cons_rd_rdy_o,
  output logic [N_CONS*DATA_W-1:0] cons_rd_data_o,
  input  logic [N_CONS-1:0]        cons_wr_vld_i,
  input  logic [N_CONS*ADDR_W-1:0] cons_wr_addr_i,
  input  logic [N_CONS*DATA_W-1:0] cons_wr_data_i,
  output logic [N_CONS-1:0]        cons_wr_rdy_o,
  output logic [N_CHAN-1:0]        mem_rd_vld_o,
  output logic [N_CHAN*ADDR_W-1:0] mem_rd_addr_o,
  input  logic [N_CHAN-1:0]        mem_rd_rdy_i,
  input  logic [N_CHAN*DATA_W-1:0] mem_rd_data_i,
  output logic [N_CHAN-1:0]        mem_wr_vld_o,
  output logic [N_CHAN*ADDR_W-1:0] mem_wr_addr_o,
  output logic [N_CHAN*DATA_W-1:0] mem_wr_data_o,
  input  logic [N_CHAN-1:0]        mem_wr_rdy_i
);
  localparam int IW = (N_CONS > 1) ? $clog2(N_CONS) : 1;

  logic [N_CONS-1:0]    wr_vld_eff;
  logic [N_CONS-1:0]    busy;
  logic [N_CHAN-1:0]    own_m [N_CONS];
  logic [N_CHAN-1:0]    ch_idle, take, take_wr, ch_wr_vld;
  logic [N_CHAN*IW-1:0] take_idx;
  ch_state_e            st  [N_CHAN];
  logic [IW-1:0]        cidx[N_CHAN];
  logic [ADDR_W-1:0]    caddr[N_CHAN];
  logic [DATA_W-1:0]    cwdat[N_CHAN];
  logic [DATA_W-1:0]    crsp [N_CHAN];

  generate
    if (WR_EN) begin : g_wr
      assign wr_vld_eff    = cons_wr_vld_i;
      assign mem_wr_vld_o  = ch_wr_vld;
    end else begin : g_ro
      assign wr_vld_eff    = '0;
      assign mem_wr_vld_o  = '0;
    end
  endgenerate

  // Requester ownership and response steering
  always_comb begin
    busy           = '0;
    cons_rd_rdy_o  = '0;
    cons_wr_rdy_o  = '0;
    cons_rd_data_o = '0;
    for (int j = 0; j < N_CONS; j++) begin
      own_m[j] = '0;
      for (int c = 0; c < N_CHAN; c++) begin
        if (st[c] != CH_IDLE && int'(cidx[c]) == j) begin
          own_m[j][c] = 1'b1;
          busy[j]     = 1'b1;
          if (st[c] == CH_RD_RELAY) begin
            cons_rd_rdy_o[j]                  = 1'b1;
            cons_rd_data_o[j*DATA_W +: DATA_W] = crsp[c];
          end
          if (st[c] == CH_WR_RELAY && WR_EN) cons_wr_rdy_o[j] = 1'b1;
        end
      end
    end
  end

  mca_pick #(
    .N_CONS(N_CONS), .N_CHAN(N_CHAN), .IW(IW)
  ) u_pick (
    .idle_i    (ch_idle),
    .rd_vld_i  (cons_rd_vld_i),
    .wr_vld_i  (wr_vld_eff),
    .busy_i    (busy),
    .take_o    (take),
    .take_idx_o(take_idx),
    .take_wr_o (take_wr)
  );

  generate
    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
      logic [IW-1:0]     t_idx;
      logic [ADDR_W-1:0] t_addr;
      logic [DATA_W-1:0] t_data;

      assign t_idx  = take_idx[c*IW +: IW];
      assign t_addr = take_wr[c] ? cons_wr_addr_i[int'(t_idx)*ADDR_W +: ADDR_W]
                                 : cons_rd_addr_i[int'(t_idx)*ADDR_W +: ADDR_W];
      assign t_data = cons_wr_data_i[int'(t_idx)*DATA_W +: DATA_W];

      mca_channel #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW)
      ) u_ch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .take_i       (take[c]),
        .take_wr_i    (take_wr[c]),
        .take_idx_i   (t_idx),
        .take_addr_i  (t_addr),
        .take_data_i  (t_data),
        .own_rd_vld_i (cons_rd_vld_i[cidx[c]]),
        .own_wr_vld_i (wr_vld_eff[cidx[c]]),
        .mem_rd_rdy_i (mem_rd_rdy_i[c]),
        .mem_rd_data_i(mem_rd_data_i[c*DATA_W +: DATA_W]),
        .mem_wr_rdy_i (mem_wr_rdy_i[c]),
        .state_o      (st[c]),
        .idx_o        (cidx[c]),
        .mem_rd_vld_o (mem_rd_vld_o[c]),
        .mem_wr_vld_o (ch_wr_vld[c]),
        .addr_o       (caddr[c]),
        .wdata_o      (cwdat[c]),
        .rsp_o        (crsp[c])
      );

      assign ch_idle[c]                       = (st[c] == CH_IDLE);
      assign mem_rd_addr_o[c*ADDR_W +: ADDR_W] = caddr[c];
      assign mem_wr_addr_o[c*ADDR_W +: ADDR_W] = caddr[c];
      assign mem_wr_data_o[c*DATA_W +: DATA_W] = cwdat[c];
    end

    for (genvar j = 0; j < N_CONS; j++) begin : g_cons_chk
      // R7
      one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(own_m[j]) <= 1);
      // R4
      rd_rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cons_rd_rdy_o[j] && cons_rd_vld_i[j] |=> cons_rd_rdy_o[j] && $stable(cons_rd_data_o[j*DATA_W +: DATA_W]));
      // R4
      rd_rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cons_rd_rdy_o[j] && !cons_rd_vld_i[j] |=> !cons_rd_rdy_o[j]);
      // R5
      wr_rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cons_wr_rdy_o[j] && cons_wr_vld_i[j] |=> cons_wr_rdy_o[j]);
    end
  endgenerate

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (mem_rd_vld_o == '0 && mem_wr_vld_o == '0 &&
                               cons_rd_rdy_o == '0 && cons_wr_rdy_o == '0);
    end
  end
endmodule

// File: tb/sim_mem_chan_arbiter.sv
module sim_mem_chan_arbiter;
  localparam int CLK_P = 10;
  localparam int AW = 8, DW = 8, NC = 4, CH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [NC-1:0]    rd_vld = '0, wr_vld = '0, rd_rdy, wr_rdy;
  logic [NC*AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [NC*DW-1:0] wr_data = '0, rd_data;
  logic [CH-1:0]    m_rd_vld, m_wr_vld, m_rd_rdy = '0, m_wr_rdy = '0;
  logic [CH*AW-1:0] m_rd_addr, m_wr_addr;
  logic [CH*DW-1:0] m_rd_data = '0, m_wr_data;

  logic [NC-1:0]    b_rd_vld = '0, b_wr_vld = '0, b_rd_rdy, b_wr_rdy;
  logic [NC*AW-1:0] b_rd_addr = '0, b_wr_addr = '0;
  logic [NC*DW-1:0] b_wr_data = '0, b_rd_data;
  logic [CH-1:0]    b_m_rd_vld, b_m_wr_vld;
  logic [CH*AW-1:0] b_m_rd_addr, b_m_wr_addr;
  logic [CH*DW-1:0] b_m_wr_data;

  mem_chan_arbiter #(.ADDR_W(AW), .DATA_W(DW), .N_CONS(NC), .N_CHAN(CH), .WR_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cons_rd_vld_i(rd_vld), .cons_rd_addr_i(rd_addr), .cons_rd_rdy_o(rd_rdy), .cons_rd_data_o(rd_data),
    .cons_wr_vld_i(wr_vld), .cons_wr_addr_i(wr_addr), .cons_wr_data_i(wr_data), .cons_wr_rdy_o(wr_rdy),
    .mem_rd_vld_o(m_rd_vld), .mem_rd_addr_o(m_rd_addr), .mem_rd_rdy_i(m_rd_rdy), .mem_rd_data_i(m_rd_data),
    .mem_wr_vld_o(m_wr_vld), .mem_wr_addr_o(m_wr_addr), .mem_wr_data_o(m_wr_data), .mem_wr_rdy_i(m_wr_rdy));

  mem_chan_arbiter #(.ADDR_W(AW), .DATA_W(DW), .N_CONS(NC), .N_CHAN(CH), .WR_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .cons_rd_vld_i(b_rd_vld), .cons_rd_addr_i(b_rd_addr), .cons_rd_rdy_o(b_rd_rdy), .cons_rd_data_o(b_rd_data),
    .cons_wr_vld_i(b_wr_vld), .cons_wr_addr_i(b_wr_addr), .cons_wr_data_i(b_wr_data), .cons_wr_rdy_o(b_wr_rdy),
    .mem_rd_vld_o(b_m_rd_vld), .mem_rd_addr_o(b_m_rd_addr), .mem_rd_rdy_i('0), .mem_rd_data_i('0),
    .mem_wr_vld_o(b_m_wr_vld), .mem_wr_addr_o(b_m_wr_addr), .mem_wr_data_o(b_m_wr_data), .mem_wr_rdy_i('0));

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1", "mem rd/wr vld", {m_rd_vld, m_wr_vld}, '0);
    chk("R1", "cons rd/wr rdy", {rd_rdy, wr_rdy}, '0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_read_single();
    rd_vld[2] = 1'b1; rd_addr[2*AW +: AW] = 8'h35;
    step();
    chk("R2", "ch0 rd vld", m_rd_vld, 2'b01);
    chk("R2", "ch0 rd addr", m_rd_addr[0 +: AW], 8'h35);
    step(2);
    chk("R2", "ch0 rd vld held", m_rd_vld[0], 1'b1);
    chk("R2", "ch0 rd addr held", m_rd_addr[0 +: AW], 8'h35);
    m_rd_rdy[0] = 1'b1; m_rd_data[0 +: DW] = 8'hA7;
    step();
    m_rd_rdy[0] = 1'b0; m_rd_data[0 +: DW] = 8'h00;
    chk("R3", "ch0 rd vld drop", m_rd_vld[0], 1'b0);
    chk("R3", "cons2 rd rdy", rd_rdy, 4'b0100);
    chk("R3", "cons2 rd data", rd_data[2*DW +: DW], 8'hA7);
    step(2);
    chk("R4", "cons2 rdy held", rd_rdy[2], 1'b1);
    chk("R4", "cons2 data held", rd_data[2*DW +: DW], 8'hA7);
    chk("R7", "no reissue on ch1", m_rd_vld, 2'b00);
    rd_vld[2] = 1'b0;
    step();
    chk("R4", "cons2 rdy clear", rd_rdy[2], 1'b0);
  endtask

  task automatic t_priority();
    wr_vld[0] = 1'b1; wr_addr[0 +: AW] = 8'h10; wr_data[0 +: DW] = 8'h5A;
    rd_vld[1] = 1'b1; rd_addr[1*AW +: AW] = 8'h11;
    rd_vld[3] = 1'b1; rd_addr[3*AW +: AW] = 8'h13;
    step();
    chk("R6", "ch0 takes cons0 write", m_wr_vld, 2'b01);
    chk("R6", "ch0 wr addr", m_wr_addr[0 +: AW], 8'h10);
    chk("R5", "ch0 wr data", m_wr_data[0 +: DW], 8'h5A);
    chk("R6", "ch1 takes cons1 read", m_rd_vld, 2'b10);
    chk("R6", "ch1 rd addr", m_rd_addr[AW +: AW], 8'h11);
    m_rd_rdy[1] = 1'b1; m_rd_data[DW +: DW] = 8'h3C;
    step();
    m_rd_rdy[1] = 1'b0;
    chk("R10", "cons1 rd rdy while ch0 waits", rd_rdy, 4'b0010);
    chk("R10", "cons1 rd data", rd_data[1*DW +: DW], 8'h3C);
    rd_vld[1] = 1'b0;
    step();
    chk("R7", "ch1 freed", m_rd_vld, 2'b00);
    step();
    chk("R7", "ch1 takes cons3", m_rd_vld, 2'b10);
    chk("R7", "ch1 addr cons3", m_rd_addr[AW +: AW], 8'h13);
    chk("R10", "ch0 write still pending", m_wr_vld, 2'b01);
    m_wr_rdy[0] = 1'b1;
    step();
    m_wr_rdy[0] = 1'b0;
    chk("R5", "mem wr vld drop", m_wr_vld[0], 1'b0);
    chk("R5", "cons0 wr rdy", wr_rdy, 4'b0001);
    step();
    chk("R5", "cons0 wr rdy held", wr_rdy[0], 1'b1);
    wr_vld[0] = 1'b0;
    step();
    chk("R5", "cons0 wr rdy clear", wr_rdy[0], 1'b0);
    m_rd_rdy[1] = 1'b1; m_rd_data[DW +: DW] = 8'h77;
    step();
    m_rd_rdy[1] = 1'b0;
    chk("R3", "cons3 rd data", rd_data[3*DW +: DW], 8'h77);
    rd_vld[3] = 1'b0;
    step();
    chk("R4", "cons3 rdy clear", rd_rdy, 4'b0000);
  endtask

  task automatic t_rd_before_wr();
    rd_vld[1] = 1'b1; rd_addr[1*AW +: AW] = 8'h21;
    wr_vld[1] = 1'b1; wr_addr[1*AW +: AW] = 8'h22; wr_data[1*DW +: DW] = 8'h99;
    step();
    chk("R8", "read first on ch0", m_rd_vld, 2'b01);
    chk("R8", "read addr", m_rd_addr[0 +: AW], 8'h21);
    chk("R8", "no write yet", m_wr_vld, 2'b00);
    m_rd_rdy[0] = 1'b1; m_rd_data[0 +: DW] = 8'h44;
    step();
    m_rd_rdy[0] = 1'b0;
    chk("R8", "read relayed", rd_rdy, 4'b0010);
    rd_vld[1] = 1'b0;
    step();
    chk("R7", "not retaken on release edge", m_wr_vld, 2'b00);
    step();
    chk("R7", "retaken next cycle as write", m_wr_vld, 2'b01);
    chk("R8", "write addr", m_wr_addr[0 +: AW], 8'h22);
    chk("R8", "write data", m_wr_data[0 +: DW], 8'h99);
    m_wr_rdy[0] = 1'b1;
    step();
    m_wr_rdy[0] = 1'b0;
    chk("R5", "cons1 wr rdy", wr_rdy, 4'b0010);
    wr_vld[1] = 1'b0;
    step();
    chk("R5", "cons1 wr rdy clear", wr_rdy, 4'b0000);
  endtask

  task automatic t_wr_disabled();
    b_wr_vld[0] = 1'b1; b_wr_addr[0 +: AW] = 8'h30; b_wr_data[0 +: DW] = 8'hEE;
    b_rd_vld[1] = 1'b1; b_rd_addr[1*AW +: AW] = 8'h31;
    step();
    chk("R9", "ch0 skips write-only cons0", b_m_rd_vld, 2'b01);
    chk("R9", "ch0 addr is cons1", b_m_rd_addr[0 +: AW], 8'h31);
    chk("R9", "no mem write", b_m_wr_vld, 2'b00);
    step(2);
    chk("R9", "no write ready", b_wr_rdy, 4'b0000);
    chk("R9", "ch1 stays free", b_m_rd_vld[1], 1'b0);
  endtask

  initial begin
    t_reset();
    t_read_single();
    t_priority();
    t_rd_before_wr();
    t_wr_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule